// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a link to a serial analog-to-digital converter that has a chip-select input, a serial clock input and a serial data output. Each pulse on `start_i` runs one read frame. The block lowers chip select, which makes the converter sample its input. It then produces a fixed number of serial clock periods, derived from the system clock. On each clock it samples the data line on the selected edge. It keeps only the result bits and presents them right-justified in a 12-bit word, together with a one-cycle valid strobe.

A frame on the wire is laid out as follows. Bit position 0 is a leading zero that the converter drives when chip select falls. Each falling serial-clock edge then launches the next position: a second leading zero, then the result MSB first, then zeros up to the end of the frame. Capturing on rising edges sees each bit half a period after it is launched. In that mode the first leading zero is never observed, so the bit index that maps to the result moves by one with the capture edge. The frame length is a parameter (14 or 16 clocks). The serial clock half-period is a parameter. After every frame, chip select is held high for a minimum quiet time before the next frame may start.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n_o`=1, `sclk_o`=1, `busy_o`=0, `valid_o`=0, `result_o`=0 and `frame_err_o`=0.
- R2: A `start_i` sampled high while idle, with the quiet time over, drives `cs_n_o` low at that same clock edge. `busy_o` is high in every cycle in which `cs_n_o` is low.
- R3: `sclk_o` is high whenever `cs_n_o` is high. The first falling serial edge comes HALF_DIV system clocks after chip select falls. Every later half period lasts HALF_DIV clocks. A frame has exactly FRAME_CLKS falling edges.
- R4: `cs_n_o` rises only after the FRAME_CLKS-th falling edge, one half period after the last rising edge. `valid_o` is high for exactly one cycle, at the edge where `cs_n_o` rises.
- R5: In falling-capture mode, the bit at frame position j (position 0 driven at chip-select fall, position j launched by falling edge j) is read at falling edge j+1. Positions 2..RES_BITS+1 are the result, MSB first.
- R6: In rising-capture mode, rising edge n reads position n. Position 0 is never read.
- R7: The result is right-justified in `result_o`, with the bits above RES_BITS at zero. Frame positions after the result have no effect on `result_o`.
- R8: `frame_err_o` is updated together with `valid_o`. It is 1 when an observed leading-zero position read as 1: positions 0 and 1 in falling mode, position 1 only in rising mode. Otherwise it is 0. The result is delivered in either case.
- R9: After `cs_n_o` rises, it stays high for at least QUIET_CLKS system clocks. A `start_i` during that quiet time, or while busy, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one read frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle strobe: result and error updated |
| result_o | output | OUT_W | Right-justified conversion result |
| frame_err_o | output | 1 | A leading-zero position read as 1 |

## Verification
The bench drives two instances against a bit-exact converter model. One is a 12-bit, 16-clock reader capturing on falling edges. The other is a 10-bit, 14-clock reader capturing on rising edges, with a longer half period.

The vectors put ones in the trailing positions and in each leading-zero position separately. A design with an off-by-one capture index, or with the shift not moving with the capture edge, returns a result shifted by one bit. It also flags the wrong leading zero, or misses one. The bench counts falling edges and the delay from chip select to the first edge, which exposes a frame that is short or long by one clock.

A start pulse is placed inside the quiet window and another is held through a frame. A design that re-arms early would lower chip select too soon, or restart mid-frame and add extra edges.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Phases of one read frame
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // chip select high, quiet time running
        ST_SETUP = 2'd1,   // chip select low, waiting for first falling edge
        ST_LOW   = 2'd2,   // serial clock low half period
        ST_HIGH  = 2'd3    // serial clock high half period
    } rd_state_e;

endpackage

// File: rtl/adc_half_timer.sv
// Half-period timer for the serial clock: one tick every HALF_DIV clocks
// while run_i is high; held cleared otherwise.
module adc_half_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(HALF_DIV - 1));
    assign tick_o = run_i && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: the half-period count never passes its terminal value
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(HALF_DIV));

    // R3: an idle timer restarts from zero
    a_r3_cnt_cleared_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/adc_bit_capture.sv
// Maps each capture edge to a frame position, collects the result bits
// MSB first and records any leading-zero position that read as one.
module adc_bit_capture #(
    parameter int RES_BITS     = 12,
    parameter int FRAME_CLKS   = 16,
    parameter bit CAPTURE_RISE = 1'b0,
    parameter int EW           = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                fall_ev_i,
    input  logic                rise_ev_i,
    input  logic [EW-1:0]       edge_num_i,   // falling edges including this one
    input  logic                sdata_i,
    output logic [RES_BITS-1:0] data_o,
    output logic                lz_err_o
);
    localparam int BW        = $clog2(RES_BITS + 1);
    localparam int FIRST_RES = 2;
    localparam int LAST_RES  = FIRST_RES + RES_BITS;   // exclusive

    typedef struct packed {
        logic [RES_BITS-1:0] data;
        logic                lz;
        logic [BW-1:0]       nbits;
    } cap_t;

    cap_t          r_d, r_q;
    logic          take;
    logic [EW-1:0] idx;

    // Rising edge n reads position n; falling edge n reads position n-1,
    // the bit that was already on the line before that edge.
    assign take = CAPTURE_RISE ? rise_ev_i : fall_ev_i;
    assign idx  = CAPTURE_RISE ? edge_num_i : (edge_num_i - EW'(1));

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d = '0;
        end else if (take) begin
            if (idx < EW'(FIRST_RES)) begin
                r_d.lz = r_q.lz | sdata_i;
            end else if (idx < EW'(LAST_RES)) begin
                r_d.data  = {r_q.data[RES_BITS-2:0], sdata_i};
                r_d.nbits = r_q.nbits + BW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o   = r_q.data;
    assign lz_err_o = r_q.lz;

    // R5: no more result bits are shifted in than the resolution holds
    a_r5_bits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.nbits <= BW'(RES_BITS));

    // R7: once the result is full, later positions leave it unchanged
    a_r7_trailing_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && r_q.nbits == BW'(RES_BITS)) |=> $stable(r_q.data));

    // R6: the capture edge never addresses position 0 in rising mode
    a_r6_no_pos0_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (CAPTURE_RISE && take) |-> edge_num_i != '0);

endmodule

// File: rtl/adc_frame_reader.sv
// Host-side reader for one serial converter frame.
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int RES_BITS     = 12,
    parameter int FRAME_CLKS   = 16,
    parameter bit CAPTURE_RISE = 1'b0,
    parameter int HALF_DIV     = 2,
    parameter int QUIET_CLKS   = 4,
    parameter int OUT_W        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sdata_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] result_o,
    output logic             frame_err_o
);
    localparam int EW = $clog2(FRAME_CLKS + 1);
    localparam int QW = $clog2(QUIET_CLKS + 2);

    typedef struct packed {
        rd_state_e        state;
        logic             cs_n;
        logic             sclk;
        logic             busy;
        logic [EW-1:0]    edges;
        logic [QW-1:0]    quiet;
        logic             valid;
        logic [OUT_W-1:0] result;
        logic             ferr;
    } rd_regs_t;

    rd_regs_t            r_d, r_q;
    logic                tick;
    logic                fall_ev;
    logic                rise_ev;
    logic                cap_clear;
    logic [EW-1:0]       edge_num;
    logic [RES_BITS-1:0] cap_data;
    logic                cap_lz;

    adc_half_timer #(
        .HALF_DIV (HALF_DIV)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.state != ST_IDLE),
        .tick_o (tick)
    );

    // A falling edge counts itself; a rising edge keeps the current count
    assign edge_num = fall_ev ? (r_q.edges + EW'(1)) : r_q.edges;

    adc_bit_capture #(
        .RES_BITS     (RES_BITS),
        .FRAME_CLKS   (FRAME_CLKS),
        .CAPTURE_RISE (CAPTURE_RISE),
        .EW           (EW)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (cap_clear),
        .fall_ev_i  (fall_ev),
        .rise_ev_i  (rise_ev),
        .edge_num_i (edge_num),
        .sdata_i    (sdata_i),
        .data_o     (cap_data),
        .lz_err_o   (cap_lz)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        fall_ev   = 1'b0;
        rise_ev   = 1'b0;
        cap_clear = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.quiet != '0) begin
                    r_d.quiet = r_q.quiet - QW'(1);
                end else if (start_i) begin
                    r_d.state = ST_SETUP;
                    r_d.cs_n  = 1'b0;
                    r_d.busy  = 1'b1;
                    r_d.edges = '0;
                    cap_clear = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    r_d.sclk  = 1'b0;
                    r_d.edges = r_q.edges + EW'(1);
                    fall_ev   = 1'b1;
                    r_d.state = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.sclk  = 1'b1;
                    rise_ev   = 1'b1;
                    r_d.state = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (r_q.edges == EW'(FRAME_CLKS)) begin
                        // conversion count reached: safe to release chip select
                        r_d.cs_n   = 1'b1;
                        r_d.busy   = 1'b0;
                        r_d.valid  = 1'b1;
                        r_d.result = OUT_W'(cap_data);
                        r_d.ferr   = cap_lz;
                        r_d.quiet  = QW'(QUIET_CLKS);
                        r_d.state  = ST_IDLE;
                    end else begin
                        r_d.sclk  = 1'b0;
                        r_d.edges = r_q.edges + EW'(1);
                        fall_ev   = 1'b1;
                        r_d.state = ST_LOW;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.cs_n   <= 1'b1;
            r_q.sclk   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o      = r_q.cs_n;
    assign sclk_o      = r_q.sclk;
    assign busy_o      = r_q.busy;
    assign valid_o     = r_q.valid;
    assign result_o    = r_q.result;
    assign frame_err_o = r_q.ferr;

    // R4: chip select is released only after the full falling-edge count
    a_r4_cs_rise_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cs_n) |-> $past(r_q.edges) == EW'(FRAME_CLKS));

    // R4: the valid strobe is a single cycle
    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |=> !r_q.valid);

    // R4: valid coincides with the release of chip select
    a_r4_valid_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> (r_q.cs_n && $past(!r_q.cs_n)));

    // R2: busy covers every cycle with chip select low
    a_r2_busy_covers_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.cs_n |-> r_q.busy);

    // R3: serial clock idles high outside a frame
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cs_n |-> r_q.sclk);

    // R3: falling-edge count never passes the frame length
    a_r3_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.edges <= EW'(FRAME_CLKS));

    // R9: a new frame begins only after the quiet time has elapsed
    a_r9_quiet_respected: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs_n) |-> $past(r_q.quiet) == '0);

endmodule

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps

// Converter model: position 0 at chip-select fall, next position on each
// falling serial edge, zero when deselected.
module tb_adc_model #(
    parameter int RES = 12
) (
    input  logic        cs_n,
    input  logic        sclk,
    input  logic [11:0] code,
    input  logic [1:0]  lz,
    input  logic        trail,
    output logic        sd
);
    int pos = 0;

    function automatic logic bit_at(input int j);
        if (j < 2) return lz[j];
        if (j < 2 + RES) return code[RES - 1 - (j - 2)];
        return trail;
    endfunction

    initial sd = 1'b0;

    always @(negedge cs_n) begin
        pos = 0;
        sd <= bit_at(0);
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            pos = pos + 1;
            sd <= bit_at(pos);
        end
    end

    always @(posedge cs_n) sd <= 1'b0;
endmodule

module tb_adc_frame_reader;
    localparam int HALF_A  = 2;
    localparam int QUIET_A = 4;
    localparam int HALF_B  = 3;
    localparam int QUIET_B = 6;

    // vector: [14:3] code, [2:1] leading-zero positions {pos1,pos0}, [0] trailing value
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {12'hABC, 2'b00, 1'b0},
        {12'hFFF, 2'b00, 1'b1},
        {12'h000, 2'b00, 1'b1},
        {12'h800, 2'b00, 1'b0},
        {12'h001, 2'b00, 1'b1},
        {12'h555, 2'b01, 1'b0},
        {12'h3C3, 2'b10, 1'b1},
        {12'h7E1, 2'b11, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0, start_b = 1'b0;
    logic [11:0] m_code = '0;
    logic [1:0]  m_lz = '0;
    logic        m_trail = 1'b0;

    logic cs_a, sclk_a, busy_a, valid_a, err_a, sd_a;
    logic cs_b, sclk_b, busy_b, valid_b, err_b, sd_b;
    logic [11:0] res_a, res_b;

    int checks = 0;
    int errors = 0;
    int sel = 0;

    always #4 clk = ~clk;

    adc_frame_reader #(
        .RES_BITS(12), .FRAME_CLKS(16), .CAPTURE_RISE(1'b0),
        .HALF_DIV(HALF_A), .QUIET_CLKS(QUIET_A), .OUT_W(12)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .sdata_i(sd_a),
        .cs_n_o(cs_a), .sclk_o(sclk_a), .busy_o(busy_a), .valid_o(valid_a),
        .result_o(res_a), .frame_err_o(err_a)
    );

    adc_frame_reader #(
        .RES_BITS(10), .FRAME_CLKS(14), .CAPTURE_RISE(1'b1),
        .HALF_DIV(HALF_B), .QUIET_CLKS(QUIET_B), .OUT_W(12)
    ) dut_b (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .sdata_i(sd_b),
        .cs_n_o(cs_b), .sclk_o(sclk_b), .busy_o(busy_b), .valid_o(valid_b),
        .result_o(res_b), .frame_err_o(err_b)
    );

    tb_adc_model #(.RES(12)) u_model_a (
        .cs_n(cs_a), .sclk(sclk_a), .code(m_code), .lz(m_lz), .trail(m_trail), .sd(sd_a));
    tb_adc_model #(.RES(10)) u_model_b (
        .cs_n(cs_b), .sclk(sclk_b), .code(m_code), .lz(m_lz), .trail(m_trail), .sd(sd_b));

    logic c_cs, c_sclk, c_busy, c_valid, c_err;
    logic [11:0] c_res;
    always_comb begin
        c_cs    = (sel != 0) ? cs_b    : cs_a;
        c_sclk  = (sel != 0) ? sclk_b  : sclk_a;
        c_busy  = (sel != 0) ? busy_b  : busy_a;
        c_valid = (sel != 0) ? valid_b : valid_a;
        c_err   = (sel != 0) ? err_b   : err_a;
        c_res   = (sel != 0) ? res_b   : res_a;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_start(input logic v);
        if (sel != 0) start_b = v; else start_a = v;
    endtask

    // Follow one frame from the negedge after chip select fell to valid
    task automatic wait_frame(input logic [11:0] exp_res, input logic exp_err);
        int  k = 0;
        int  falls = 0;
        int  first = -1;
        int  busy_bad = 0;
        logic prev = 1'b1;
        int  half = (sel != 0) ? HALF_B : HALF_A;
        int  nclk = (sel != 0) ? 14 : 16;
        while (!c_valid && k < 2000) begin
            @(negedge clk);
            k++;
            if (prev && !c_sclk) begin
                falls++;
                if (first < 0) first = k;
            end
            if (!c_cs && !c_busy) busy_bad++;
            prev = c_sclk;
        end
        chk("R4 valid strobe seen", 32'(c_valid), 32'd1);
        chk("R2 busy while cs low", busy_bad, 0);
        chk("R3 falling edge count", falls, nclk);
        chk("R3 cs fall to first edge", first, half);
        chk("R4 cs released at valid", 32'(c_cs), 32'd1);
        chk("R3 sclk high at release", 32'(c_sclk), 32'd1);
        chk("R5 R6 R7 result", 32'(c_res), 32'(exp_res));
        chk("R8 frame error", 32'(c_err), 32'(exp_err));
        @(negedge clk);
        chk("R4 valid single cycle", 32'(c_valid), 32'd0);
    endtask

    task automatic run_frame(input logic [14:0] v);
        logic [11:0] code = v[14:3];
        logic [1:0]  lz   = v[2:1];
        logic [11:0] er;
        logic        ee;
        if (sel != 0) begin
            er = code & 12'h3FF;
            ee = lz[1];          // R6: position 0 is never read
        end else begin
            er = code;
            ee = |lz;
        end
        m_code  = code;
        m_lz    = lz;
        m_trail = v[0];
        repeat (10) @(negedge clk);
        set_start(1'b1);
        @(negedge clk);
        set_start(1'b0);
        chk("R2 cs low after start", 32'(c_cs), 32'd0);
        chk("R2 busy after start", 32'(c_busy), 32'd1);
        wait_frame(er, ee);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state on both instances
        repeat (3) @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            sel = s;
            #1;
            chk("R1 cs_n in reset", 32'(c_cs), 32'd1);
            chk("R1 sclk in reset", 32'(c_sclk), 32'd1);
            chk("R1 busy in reset", 32'(c_busy), 32'd0);
            chk("R1 valid in reset", 32'(c_valid), 32'd0);
            chk("R1 result in reset", 32'(c_res), 32'd0);
            chk("R1 error in reset", 32'(c_err), 32'd0);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        sel = 0;
        #1;
        chk("R1 idle after reset", 32'(c_cs), 32'd1);

        // table walk on both configurations (R5 falling, R6 rising, R7, R8)
        for (int i = 0; i < NV; i++) begin
            sel = 0;
            run_frame(VEC[i]);
            sel = 1;
            run_frame(VEC[i]);
        end

        // R9: start inside the quiet window is ignored, quiet time respected
        for (int s = 0; s < 2; s++) begin
            int hi;
            int q;
            sel = s;
            q = (s != 0) ? QUIET_B : QUIET_A;
            run_frame(VEC[0]);
            // now one negedge past the valid strobe; chip select rose 1.5 cycles ago
            hi = 2;
            set_start(1'b1);
            @(negedge clk);
            set_start(1'b0);
            if (c_cs) hi++;
            @(negedge clk);
            if (c_cs) hi++;
            chk("R9 start in quiet ignored cs", 32'(c_cs), 32'd1);
            chk("R9 start in quiet ignored busy", 32'(c_busy), 32'd0);
            m_code = 12'h29A;
            m_lz = 2'b00;
            m_trail = 1'b1;
            set_start(1'b1);
            for (int w = 0; w < 50 && c_cs; w++) begin
                @(negedge clk);
                if (c_cs) hi++;
            end
            chk("R9 quiet time length", 32'(hi >= q), 32'd1);
            chk("R2 frame began after quiet", 32'(c_cs), 32'd0);
            // start held high through the frame must not restart it (R9)
            wait_frame((s != 0) ? 12'h29A & 12'h3FF : 12'h29A, 1'b0);
            set_start(1'b0);
        end

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule